// File: doc/BRIEF.md
# Station Address Register and Destination Filter

This block sits in the receive path of an Ethernet MAC. It keeps the node's 48-bit individual (station) address and compares the destination address of each received frame against it. A host reaches the address through a byte-wide register port. It sets a pointer-enable bit and then makes six data accesses in a row, which step through address bytes 0 to 5. Byte 0 is the first destination byte on the wire.

While the receiver is off, the host may reach the address at any time. Once the receiver is on, the address is locked. To unlock it, the host raises a change request and polls that bit until the hardware drops it. The hardware drops it only when no frame is in progress, so the address never changes under a frame that is being compared.

On the receive side, the first six bytes of each frame form the destination address. One cycle after the sixth byte, the block pulses `match_vld`. With that pulse it presents two results: a physical-match flag, and the group flag taken from bit 0 of the first byte.

Top module: `station_addr_filter`

Register map, selected by `reg_addr`:

- Offset 0, control.
  - Bit 0: receive on.
  - Bit 1: physical compare off.
  - Bit 7: soft reset. It is write-only and reads as 0.
- Offset 1, access.
  - Bit 0: pointer enable.
  - Bit 1: change request. Reading it gives 1 while the request is pending.
- Offset 2, address data.
- Offset 3 reads as 0.

The access state machine has three states:

- HS_OPEN: access is allowed whenever the pointer bit is set.
- HS_LOCKED: all address access is refused.
- HS_PENDING: a change request is waiting for the receiver to be idle.

Its transitions are:

- HS_OPEN to HS_LOCKED (lock): receive-on is written from 0 to 1, or the pointer bit is written from 1 to 0 while receive is on.
- Any state to HS_PENDING (request): a 1 is written to the change-request bit.
- HS_PENDING to HS_OPEN (grant): the cycle in which `rx_frame` is low.
- Any state to HS_OPEN (soft reset).

The receive state machine also has three states:

- RX_IDLE: waiting for the first byte of a frame.
- RX_DA: collecting destination bytes.
- RX_BODY: skipping the rest of the frame.

Its transitions are:

- RX_IDLE to RX_DA: the first valid byte arrives while `rx_frame` is high.
- RX_DA to RX_BODY: the sixth byte is taken.
- RX_DA or RX_BODY to RX_IDLE: `rx_frame` goes low.

## Requirements
- R1: After reset, control and access registers read 0, `match_vld` is 0, and address-data reads return 0.
- R2: With receive off and pointer bit (access bit 0) set, six consecutive data writes store bytes 0..5 (byte 0 = bits 7:0, first on the wire); six reads return them in that order, and the next access wraps to byte 0.
- R3: Any write to the access register (offset 1) returns the byte index to 0.
- R4: After receive-on (control bit 0) is written 0 to 1, or the pointer bit is written 1 to 0 while receive is on, data writes leave the address unchanged and data reads return 0.
- R5: Writing 1 to access bit 1 makes it read back as 1. While it is pending, data writes are ignored, data reads return 0 and the byte index does not advance.
- R6: A pending change request clears in the cycle after one in which `rx_frame` is low. While `rx_frame` stays high it remains set. Once it has cleared, data access with the pointer bit set is allowed again.
- R7: The first six valid bytes after `rx_frame` goes high form the destination. `match_vld` pulses for exactly one cycle, in the cycle after the sixth byte. `phys_match` is 1 only if all six bytes equal the stored address.
- R8: `dest_group` equals bit 0 of the first destination byte. When it is 1, `phys_match` is 0 even if the bytes are equal.
- R9: While control bit 1 (physical compare off) is set, `phys_match` is 0 at every `match_vld`.
- R10: A frame that ends (`rx_frame` low) before its sixth valid byte produces no `match_vld`, and the next frame is compared from its own first byte.
- R11: Writing control bit 7 clears receive-on, compare-off, the pointer bit, the change request and the byte index, and reopens access. The stored address is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the index on data reads) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| rx_frame | input | 1 | High for the duration of a received frame |
| rx_vld | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte, first byte after the start delimiter first |
| match_vld | output | 1 | One-cycle pulse: destination results are valid |
| phys_match | output | 1 | Destination equals the station address |
| dest_group | output | 1 | First destination bit was 1 (group address) |

## Verification
The assertions check the following on every cycle:

- The byte index stays within range.
- A refused data write never changes the stored address.
- A pending request reads as zero data.
- A pending request is released and held according to `rx_frame`.
- `match_vld` is a single-cycle pulse.
- A group destination or an active compare-off never yields a physical match.

Only the bench's scenarios can show the following:

- The byte ordering of host access and the wrap after byte 5.
- Locking on receive enable and on pointer release.
- The full request, poll and grant sequence.
- Equal versus unequal destinations.
- Truncated frames.
- The retention of the address across a soft reset.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ACC  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int CTRL_RXON    = 0;
    localparam int CTRL_PHYSOFF = 1;
    localparam int CTRL_SRST    = 7;
    localparam int ACC_PTR      = 0;
    localparam int ACC_CHG      = 1;

    typedef enum logic [1:0] {
        HS_OPEN    = 2'd0,
        HS_LOCKED  = 2'd1,
        HS_PENDING = 2'd2
    } hs_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DA   = 2'd1,
        RX_BODY = 2'd2
    } rx_state_e;

endpackage

// File: rtl/sa_access_fsm.sv
module sa_access_fsm
    import sa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic lock_evt,
    input  logic chg_req,
    input  logic rx_frame,
    output logic access_open,
    output logic chg_pending
);

    hs_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_OPEN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = HS_OPEN;
        end else if (chg_req) begin
            state_d = HS_PENDING;
        end else begin
            unique case (state_q)
                HS_OPEN:    if (lock_evt) state_d = HS_LOCKED;
                HS_LOCKED:  state_d = HS_LOCKED;
                HS_PENDING: if (!rx_frame) state_d = HS_OPEN;
                default:    state_d = HS_OPEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        access_open = (state_q == HS_OPEN);
        chg_pending = (state_q == HS_PENDING);
    end

endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
    import sa_pkg::*;
#(
    parameter int N_BYTES = 6,
    localparam int IDX_W  = $clog2(N_BYTES),
    localparam int SA_W   = 8 * N_BYTES
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             access_open,
    input  logic             chg_pending,
    output logic             soft_rst,
    output logic             lock_evt,
    output logic             chg_req,
    output logic             phys_off,
    output logic [IDX_W-1:0] byte_idx,
    output logic [SA_W-1:0]  station_addr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

    logic       rx_on_q, ptr_q;
    logic [7:0] sa_q [N_BYTES];
    logic       wr_ctrl, wr_acc, access_ok, data_acc, data_wr;

    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
        wr_acc    = reg_wr && (reg_addr == REG_ACC);
        soft_rst  = wr_ctrl && reg_wdata[CTRL_SRST];
        chg_req   = wr_acc && reg_wdata[ACC_CHG];
        lock_evt  = (wr_ctrl && !reg_wdata[CTRL_SRST] && reg_wdata[CTRL_RXON] && !rx_on_q)
                 || (wr_acc && rx_on_q && ptr_q && !reg_wdata[ACC_PTR]);
        access_ok = access_open && ptr_q;
        data_acc  = (reg_wr || reg_rd) && (reg_addr == REG_DATA) && access_ok;
        data_wr   = reg_wr && (reg_addr == REG_DATA) && access_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_on_q  <= 1'b0;
            phys_off <= 1'b0;
            ptr_q    <= 1'b0;
            byte_idx <= '0;
        end else if (soft_rst) begin
            rx_on_q  <= 1'b0;
            phys_off <= 1'b0;
            ptr_q    <= 1'b0;
            byte_idx <= '0;
        end else begin
            if (wr_ctrl) begin
                rx_on_q  <= reg_wdata[CTRL_RXON];
                phys_off <= reg_wdata[CTRL_PHYSOFF];
            end
            if (wr_acc) begin
                ptr_q    <= reg_wdata[ACC_PTR];
                byte_idx <= '0;
            end else if (data_acc) begin
                byte_idx <= (byte_idx == LAST) ? '0 : byte_idx + 1'b1;
            end
        end
    end

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     sa_q[b] <= '0;
            else if (data_wr && (byte_idx == IDX_W'(b)))    sa_q[b] <= reg_wdata;
        end
        assign station_addr[8*b +: 8] = sa_q[b];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_RXON]    = rx_on_q;
                reg_rdata[CTRL_PHYSOFF] = phys_off;
            end
            REG_ACC: begin
                reg_rdata[ACC_PTR] = ptr_q;
                reg_rdata[ACC_CHG] = chg_pending;
            end
            REG_DATA: begin
                if (access_ok && (int'(byte_idx) < N_BYTES)) reg_rdata = sa_q[byte_idx];
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sa_rx_compare.sv
module sa_rx_compare
    import sa_pkg::*;
#(
    parameter int N_BYTES = 6,
    localparam int IDX_W  = $clog2(N_BYTES),
    localparam int SA_W   = 8 * N_BYTES
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_frame,
    input  logic            rx_vld,
    input  logic [7:0]      rx_byte,
    input  logic [SA_W-1:0] station_addr,
    input  logic            phys_off,
    output logic            match_vld,
    output logic            phys_match,
    output logic            dest_group
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

    rx_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             eq_q, grp_q;
    logic [7:0]       sa_b [N_BYTES];
    logic             take, byte_ok, eq_now, grp_now;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_sel
        assign sa_b[b] = station_addr[8*b +: 8];
    end

    always_comb begin
        take    = rx_frame && rx_vld && (state_q != RX_BODY);
        byte_ok = (int'(cnt_q) < N_BYTES) && (rx_byte == sa_b[cnt_q]);
        eq_now  = ((cnt_q == '0) ? 1'b1 : eq_q) && byte_ok;
        grp_now = (cnt_q == '0) ? rx_byte[0] : grp_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (take) state_d = (cnt_q == LAST) ? RX_BODY : RX_DA;
            RX_DA: begin
                if (!rx_frame)                    state_d = RX_IDLE;
                else if (take && cnt_q == LAST)   state_d = RX_BODY;
            end
            RX_BODY: if (!rx_frame) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // outputs and destination accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            eq_q       <= 1'b0;
            grp_q      <= 1'b0;
            match_vld  <= 1'b0;
            phys_match <= 1'b0;
            dest_group <= 1'b0;
        end else begin
            match_vld <= 1'b0;
            if (!rx_frame || state_q == RX_BODY) begin
                cnt_q <= '0;
            end else if (take) begin
                eq_q  <= eq_now;
                grp_q <= grp_now;
                if (cnt_q == LAST) begin
                    cnt_q      <= '0;
                    match_vld  <= 1'b1;
                    phys_match <= eq_now && !grp_now && !phys_off;
                    dest_group <= grp_now;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/station_addr_filter.sv
module station_addr_filter
    import sa_pkg::*;
#(
    parameter int N_BYTES = 6
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_frame,
    input  logic       rx_vld,
    input  logic [7:0] rx_byte,
    output logic       match_vld,
    output logic       phys_match,
    output logic       dest_group
);

    localparam int IDX_W = $clog2(N_BYTES);
    localparam int SA_W  = 8 * N_BYTES;

    logic             soft_rst, lock_evt, chg_req;
    logic             access_open, chg_pending, phys_off;
    logic [IDX_W-1:0] byte_idx;
    logic [SA_W-1:0]  station_addr;

    sa_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .lock_evt    (lock_evt),
        .chg_req     (chg_req),
        .rx_frame    (rx_frame),
        .access_open (access_open),
        .chg_pending (chg_pending)
    );

    sa_host_regs #(.N_BYTES(N_BYTES)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .access_open  (access_open),
        .chg_pending  (chg_pending),
        .soft_rst     (soft_rst),
        .lock_evt     (lock_evt),
        .chg_req      (chg_req),
        .phys_off     (phys_off),
        .byte_idx     (byte_idx),
        .station_addr (station_addr)
    );

    sa_rx_compare #(.N_BYTES(N_BYTES)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_frame     (rx_frame),
        .rx_vld       (rx_vld),
        .rx_byte      (rx_byte),
        .station_addr (station_addr),
        .phys_off     (phys_off),
        .match_vld    (match_vld),
        .phys_match   (phys_match),
        .dest_group   (dest_group)
    );

endmodule

// File: rtl/station_addr_filter_chk.sv
module station_addr_filter_chk
    import sa_pkg::*;
#(
    parameter int N_BYTES = 6,
    localparam int IDX_W  = $clog2(N_BYTES),
    localparam int SA_W   = 8 * N_BYTES
)(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             rx_frame,
    input logic             match_vld,
    input logic             phys_match,
    input logic             dest_group,
    input logic             access_open,
    input logic             chg_pending,
    input logic             phys_off,
    input logic [IDX_W-1:0] byte_idx,
    input logic [SA_W-1:0]  station_addr
);

    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(byte_idx) < N_BYTES);

    a_r4_refused_write_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_open && reg_wr && reg_addr == REG_DATA) |=> $stable(station_addr));

    a_r5_pending_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pending && reg_addr == REG_DATA) |-> (reg_rdata == 8'h00));

    a_r6_pending_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pending && !rx_frame && !(reg_wr && reg_addr == REG_ACC && reg_wdata[ACC_CHG]))
        |=> !chg_pending);

    a_r6_pending_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pending && rx_frame && !(reg_wr && reg_addr == REG_CTRL && reg_wdata[CTRL_SRST]))
        |=> chg_pending);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |=> !match_vld);

    a_r8_group_never_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && dest_group) |-> !phys_match);

    a_r9_compare_off: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && $past(phys_off)) |-> !phys_match);

endmodule

bind station_addr_filter station_addr_filter_chk #(.N_BYTES(N_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .rx_frame     (rx_frame),
    .match_vld    (match_vld),
    .phys_match   (phys_match),
    .dest_group   (dest_group),
    .access_open  (access_open),
    .chg_pending  (chg_pending),
    .phys_off     (phys_off),
    .byte_idx     (byte_idx),
    .station_addr (station_addr)
);

// File: tb/station_addr_filter_tb.sv
module station_addr_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_ACC = 2'd1, A_DATA = 2'd2;
    localparam logic [47:0] SA = 48'h56_44_33_22_11_02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_frame = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       match_vld, phys_match, dest_group;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    station_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_frame(rx_frame), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .match_vld(match_vld), .phys_match(phys_match), .dest_group(dest_group)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic send_da(input logic [47:0] da, input int n,
                           output logic mv, output logic pm, output logic grp);
        @(negedge clk);
        rx_frame = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_byte = da[8*i +: 8];
        end
        @(negedge clk);
        rx_vld = 1'b0;
        #1 mv = match_vld; pm = phys_match; grp = dest_group;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1 mv = mv | match_vld;
        end
        rx_frame = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        reg_read(A_CTRL, d); check("R1", "control after reset", d, 8'h00);
        reg_read(A_ACC, d);  check("R1", "access after reset", d, 8'h00);
        reg_read(A_DATA, d); check("R1", "data without pointer", d, 8'h00);
        check("R1", "match_vld after reset", match_vld, 1'b0);
    endtask

    task automatic t_open_access();
        logic [7:0] d;
        reg_write(A_ACC, 8'h01);
        for (int i = 0; i < 6; i++) reg_write(A_DATA, SA[8*i +: 8]);
        for (int i = 0; i < 6; i++) begin
            reg_read(A_DATA, d); check("R2", "byte read order", d, SA[8*i +: 8]);
        end
        reg_read(A_DATA, d); check("R2", "wrap to byte 0", d, SA[7:0]);
        reg_read(A_DATA, d); check("R2", "byte 1 after wrap", d, SA[15:8]);
        reg_write(A_ACC, 8'h01);
        reg_read(A_DATA, d); check("R3", "index reset by access write", d, SA[7:0]);
        reg_write(A_ACC, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        reg_write(A_CTRL, 8'h01);
        reg_read(A_CTRL, d); check("R4", "receive on readback", d, 8'h01);
        reg_write(A_ACC, 8'h01);
        reg_read(A_DATA, d); check("R4", "read locked after receive on", d, 8'h00);
        reg_write(A_DATA, 8'hFF);
    endtask

    task automatic t_handshake_idle();
        logic [7:0] d;
        reg_write(A_ACC, 8'h03);
        reg_read(A_ACC, d);  check("R5", "change request reads 1", d, 8'h03);
        reg_read(A_ACC, d);  check("R6", "request cleared when idle", d, 8'h01);
        reg_read(A_DATA, d); check("R4", "locked write ignored, byte 0 kept", d, SA[7:0]);
        reg_write(A_ACC, 8'h00);
        reg_write(A_ACC, 8'h01);
        reg_read(A_DATA, d); check("R4", "relocked after pointer release", d, 8'h00);
    endtask

    task automatic t_handshake_frame();
        logic [7:0] d;
        @(negedge clk); rx_frame = 1'b1;
        reg_write(A_ACC, 8'h03);
        reg_read(A_ACC, d);  check("R6", "request held in frame", d, 8'h03);
        reg_read(A_DATA, d); check("R5", "pending read returns 0", d, 8'h00);
        reg_write(A_DATA, 8'hEE);
        reg_read(A_ACC, d);  check("R6", "request still held", d, 8'h03);
        @(negedge clk); rx_frame = 1'b0;
        reg_read(A_ACC, d);  check("R6", "request cleared at frame end", d, 8'h01);
        reg_read(A_DATA, d); check("R5", "pending write ignored, index kept", d, SA[7:0]);
        reg_write(A_ACC, 8'h00);
    endtask

    task automatic t_frames();
        logic mv, pm, grp;
        send_da(SA, 6, mv, pm, grp);
        check("R7", "equal dest valid", mv, 1'b1);
        check("R7", "equal dest match", pm, 1'b1);
        check("R8", "individual dest group flag", grp, 1'b0);
        send_da(SA ^ 48'h01_00_00_00_00_00, 6, mv, pm, grp);
        check("R7", "last byte differs valid", mv, 1'b1);
        check("R7", "last byte differs no match", pm, 1'b0);
        send_da(SA ^ 48'h00_00_00_00_80_00, 6, mv, pm, grp);
        check("R7", "byte 1 differs no match", pm, 1'b0);
    endtask

    task automatic t_phys_off();
        logic mv, pm, grp;
        reg_write(A_CTRL, 8'h03);
        send_da(SA, 6, mv, pm, grp);
        check("R9", "compare off valid", mv, 1'b1);
        check("R9", "compare off no match", pm, 1'b0);
        reg_write(A_CTRL, 8'h01);
        send_da(SA, 6, mv, pm, grp);
        check("R9", "compare back on match", pm, 1'b1);
    endtask

    task automatic t_short();
        logic mv, pm, grp;
        send_da(SA, 3, mv, pm, grp);
        check("R10", "short frame no valid", mv, 1'b0);
        send_da(SA, 6, mv, pm, grp);
        check("R10", "next frame compared fresh", pm, 1'b1);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        logic mv, pm, grp;
        reg_write(A_CTRL, 8'h80);
        reg_read(A_CTRL, d); check("R11", "control cleared", d, 8'h00);
        reg_read(A_ACC, d);  check("R11", "access cleared", d, 8'h00);
        reg_write(A_ACC, 8'h01);
        reg_read(A_DATA, d); check("R11", "reopened, address kept", d, SA[7:0]);
        reg_write(A_ACC, 8'h01);
        reg_write(A_DATA, 8'h03);
        reg_write(A_ACC, 8'h00);
        send_da({SA[47:8], 8'h03}, 6, mv, pm, grp);
        check("R8", "group dest valid", mv, 1'b1);
        check("R8", "group flag set", grp, 1'b1);
        check("R8", "group dest never matches", pm, 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_open_access();
        t_lock();
        t_handshake_idle();
        t_handshake_frame();
        t_frames();
        t_phys_off();
        t_short();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule